// File: doc/BRIEF.md
# Saturating Dual-Step Counter

This block is a synchronous up-counter whose increment can be chosen at run time: one per enabled clock edge, or two. It never wraps. On reaching the top of its range it stays there until reset. When the step of two is selected, the count moves onto even values and stays on them. An odd count is first aligned upward by one, and then it advances in steps of two up to the largest even value.

The count comes straight from a register, so the output does not glitch. A synchronous reset clears it and takes precedence over every other input. An enable input gates all movement of the count. The width is a parameter. The default is 8 bits, which gives a range of 0 to 255.

Top module: `sat_step_counter`

## Requirements
- R1: When `rst` is 1 at a rising edge, `count` is 0 after that edge, whatever `en` and `step2` are.
- R2: When `rst` is 0 and `en` is 0 at a rising edge, `count` keeps its value.
- R3: With `step2` = 0 (step of one) and `en` = 1, a count below 255 becomes count + 1.
- R4: With `step2` = 0 and `en` = 1, a count of 255 stays at 255 and never wraps.
- R5: With `step2` = 1 (step of two) and `en` = 1, an even count below 254 becomes count + 2.
- R6: With `step2` = 1 and `en` = 1, a count of 254 stays at 254.
- R7: With `step2` = 1 and `en` = 1, an odd count below 255 becomes count + 1, which is even.
- R8: With `step2` = 1 and `en` = 1, a count of 255 becomes 254.
- R9: After any edge with `rst` = 0, `en` = 1 and `step2` = 1, bit 0 of `count` is 0.
- R10: When `step2` goes from 1 back to 0, counting continues in single steps from the current even value, with no realignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| en | input | 1 | Count enable, active high |
| step2 | input | 1 | Step select: 0 steps by one, 1 steps by two |
| count | output | WIDTH (8) | Registered count value |

## Verification
The bench builds the counter with the default width of 8. At this width both ceilings, 254 and 255, are reached within a few hundred cycles. Walking the count up to each ceiling lets the bench hit the saturation cases and the mode switches made right at the top. These include 255 falling back to 254 and 254 climbing to 255 after the step returns to one. Odd-to-even alignment, enable gaps in both modes, and reset asserted together with enable are also driven, and each result is compared with a behavioural model on every edge.

// File: rtl/sat_step_pkg.sv
package sat_step_pkg;

    localparam int unsigned CNT_W = 8;

    // Register image of the counter: only the count value is stored.
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

endpackage

// File: rtl/sat_step_ceiling.sv
// Chooses the saturation ceiling that goes with the selected step size.
module sat_step_ceiling #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             step2,
    output logic [WIDTH-1:0] ceiling
);
    localparam logic [WIDTH-1:0] TOP_ANY  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TOP_EVEN = {{(WIDTH-1){1'b1}}, 1'b0};

    always_comb begin
        ceiling = step2 ? TOP_EVEN : TOP_ANY;
    end
endmodule

// File: rtl/sat_step_incr.sv
// Works out the next count value: step amount, parity alignment and clamping.
module sat_step_incr #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             step2,
    input  logic [WIDTH-1:0] ceiling,
    output logic [WIDTH-1:0] nxt
);
    logic [WIDTH:0] amount;
    logic [WIDTH:0] sum;
    logic           above_ceiling;
    logic           sum_clamps;

    always_comb begin
        // An odd value in the step-of-two mode first moves one place up to become even.
        if (step2 && !cur[0]) begin
            amount = (WIDTH+1)'(2);
        end else begin
            amount = (WIDTH+1)'(1);
        end
        sum           = {1'b0, cur} + amount;
        above_ceiling = (cur > ceiling);
        sum_clamps    = (sum > {1'b0, ceiling});
        if (above_ceiling || sum_clamps) begin
            nxt = ceiling;
        end else begin
            nxt = sum[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/sat_step_counter.sv
module sat_step_counter #(
    parameter int unsigned WIDTH = sat_step_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             step2,
    output logic [WIDTH-1:0] count
);
    logic [WIDTH-1:0] count_d;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] ceiling;
    logic [WIDTH-1:0] advanced;

    sat_step_ceiling #(.WIDTH(WIDTH)) u_ceiling (
        .step2   (step2),
        .ceiling (ceiling)
    );

    sat_step_incr #(.WIDTH(WIDTH)) u_incr (
        .cur     (count_q),
        .step2   (step2),
        .ceiling (ceiling),
        .nxt     (advanced)
    );

    // Next-state process: reset, then enable, then hold.
    always_comb begin
        count_d = count_q;
        if (rst) begin
            count_d = '0;
        end else if (en) begin
            count_d = advanced;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    assign count = count_q;
endmodule

// File: rtl/sat_step_counter_chk.sv
module sat_step_counter_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             step2,
    input logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] TOP_ANY  = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] TOP_EVEN = {{(WIDTH-1){1'b1}}, 1'b0};

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst |=> count == '0);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !step2 && count != TOP_ANY) |=> count == $past(count) + WIDTH'(1));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !step2 && count == TOP_ANY) |=> count == TOP_ANY);

    // R5
    double_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step2 && !count[0] && count != TOP_EVEN) |=> count == $past(count) + WIDTH'(2));

    // R6
    even_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step2 && count == TOP_EVEN) |=> count == TOP_EVEN);

    // R7
    odd_align_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step2 && count[0] && count != TOP_ANY) |=> count == $past(count) + WIDTH'(1));

    // R8
    top_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step2 && count == TOP_ANY) |=> count == TOP_EVEN);

    // R9
    even_output_chk: assert property (@(posedge clk) disable iff (rst)
        (en && step2) |=> !count[0]);
endmodule

bind sat_step_counter sat_step_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .step2 (step2),
    .count (count)
);

// File: tb/sat_step_counter_test.sv
`timescale 1ns/1ps
module sat_step_counter_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic         step2 = 1'b0;
    logic [W-1:0] count;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sat_step_counter #(.WIDTH(W)) uut (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .step2 (step2),
        .count (count)
    );

    function automatic string pick_tag(input bit r, input bit e, input bit s, input int c);
        if (r) return "R1";
        if (!e) return "R2";
        if (!s) return (c == 255) ? "R4" : "R3";
        if (c == 255) return "R8";
        if (c == 254) return "R6";
        if (c % 2 == 1) return "R7";
        return "R5";
    endfunction

    function automatic int ref_next(input bit r, input bit e, input bit s, input int c);
        if (r) return 0;
        if (!e) return c;
        if (!s) return (c >= 255) ? 255 : c + 1;
        if (c % 2 == 1) return (c == 255) ? 254 : c + 1;
        return (c + 2 > 254) ? 254 : c + 2;
    endfunction

    task automatic check(input string tag, input int exp);
        checks++;
        if (int'(count) != exp) begin
            errors++;
            $display("FAIL %s: count=%0d expected=%0d", tag, count, exp);
        end
    endtask

    // One clock: inputs are set at the falling edge, the result is sampled 1 ns after the rising edge.
    task automatic tick(input bit r, input bit e, input bit s, input string extra = "");
        string tag;
        @(negedge clk);
        rst = r; en = e; step2 = s;
        tag = pick_tag(r, e, s, model);
        if (extra != "") tag = {extra, "/", tag};
        @(posedge clk);
        model = ref_next(r, e, s, model);
        #1;
        check(tag, model);
        if (s && e && !r) begin
            checks++;
            if (count[0] !== 1'b0) begin
                errors++;
                $display("FAIL R9: count=%0d expected even", count);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state (R1).
        tick(1, 0, 0);
        tick(1, 1, 1);
        // Single steps, then a gap with enable low (R3, R2).
        for (int i = 0; i < 7; i++) tick(0, 1, 0);
        for (int i = 0; i < 3; i++) tick(0, 0, 1);
        // Odd count 7 with the step of two: align, then double steps (R7, R5, R9).
        for (int i = 0; i < 6; i++) tick(0, 1, 1);
        // Back to single steps from an even value (R10).
        for (int i = 0; i < 3; i++) tick(0, 1, 0, "R10");
        // Reset asserted together with enable and step select (R1 priority).
        tick(1, 1, 1);
        tick(1, 1, 0);
        // Double steps all the way to 254 and beyond (R5, R6).
        for (int i = 0; i < 132; i++) tick(0, 1, 1);
        tick(0, 0, 1);
        // Step of one from 254 up to 255, then hold at the top (R10, R4).
        tick(0, 1, 0, "R10");
        for (int i = 0; i < 4; i++) tick(0, 1, 0);
        tick(0, 0, 0);
        // Step of two selected at 255 (R8, R6).
        for (int i = 0; i < 3; i++) tick(0, 1, 1);
        // Odd value near the top: 253 aligns to 254 (R7).
        tick(1, 0, 0);
        for (int i = 0; i < 253; i++) tick(0, 1, 0);
        tick(0, 0, 1);
        tick(0, 1, 1);
        tick(0, 1, 1);
        // Final reset (R1).
        tick(1, 1, 1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule